// File: doc/BRIEF.md
# Five-Stage Pipelined 16-Bit Processor Core

This block is a small in-order processor with a 16-bit word-addressed datapath and five stages: fetch, decode with register read, execute or address calculation, memory access, and write-back. Each instruction takes one slot in the program store, so the program counter advances by one per instruction. Every instruction carries its decoded control and operand data through each pipeline register. Results from the memory and write-back stages are forwarded back into execute. A load that is followed at once by a dependent instruction causes a one-cycle stall. Taken branches and jumps are resolved in execute, and the two younger instructions are discarded.

The program store is filled through a valid/ready load stream. That stream accepts words only while the core is held in reset, which means `ld_ready` follows the reset pin. After release, the core runs from address 0. Its effects are visible on two outbound streams. The retire stream reports each register write to a nonzero register in program order. The store stream reports each data-memory write as it happens. Neither outbound stream can be held off, so a consumer must take every beat on which valid is high.

Instruction fields: opcode in bits 15:12, rs in bits 11:9, rt in bits 8:6, rd in bits 5:3, a function code in bits 2:0, a signed 6-bit immediate in bits 5:0, and a 12-bit jump target in bits 11:0. The opcodes are as follows. Opcode 0 is a register operation, with function codes 0 add, 1 subtract, 2 AND, 3 OR and 4 signed less-than; any other function code does nothing. Opcode 1 is compare-with-immediate, 2 is load, 3 is store, 4 is branch-if-equal and 5 is jump. Every other opcode is a no-op. The word 0x0000 therefore writes r0 and has no effect.

Top module: `pipe16_core`

## Requirements
- R1: `ld_ready` is high exactly while `rst_n` is low. A program word is written at `ld_addr` only on a clock edge where `ld_valid` and `ld_ready` are both high. A load beat offered while the core runs is ignored.
- R2: Reset clears the PC to 0, clears every pipeline register to a no-op and clears r1 to r7. `ret_valid` and `st_valid` stay low during reset, and `ret_valid` stays low for the first four edges after release.
- R3: The register operations write rd with rs+rt, rs-rt, rs&rt, rs|rt, or 1/0 for signed rs<rt, selected by function codes 0 to 4.
- R4: Opcode 1 writes rt with 1 when signed rs is less than the sign-extended immediate, and with 0 otherwise.
- R5: Opcode 3 writes rt to data word rs+sext(imm). In the same cycle `st_valid` is high with `st_addr` set to that sum and `st_data` set to rt. Addresses wrap modulo the data-memory depth.
- R6: Opcode 2 writes rt with the data word at rs+sext(imm), and it sees a store by the instruction just before it.
- R7: r0 reads as zero, a write to it is dropped, and no forwarding path supplies a value for r0.
- R8: Back-to-back dependent register operations get the correct operand with no stall. This holds whether the producer is one ahead (memory stage) or two ahead (write-back stage), and when it is three ahead through the same-cycle register-file bypass. Without hazards, instruction i retires on edge i+4.
- R9: An instruction whose rs or rt names the destination of the load directly ahead of it is held one cycle: the PC and the fetch/decode register hold, and a bubble enters execute.
- R10: Opcode 4 compares rs with rt in execute. When they are equal, the PC becomes PC+1+sext(imm) and the two younger instructions are discarded. When they differ, execution falls through.
- R11: Opcode 5 loads the PC with the zero-extended 12-bit target and discards the two younger instructions.
- R12: `ret_valid` is high for one cycle per retiring write to r1 to r7, with `ret_rd` and `ret_data` giving the destination and the value, in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Program word offered |
| ld_ready | output | 1 | Program store accepts words (reset held) |
| ld_addr | input | IMEM_AW | Program store word address |
| ld_data | input | 16 | Program word |
| ret_valid | output | 1 | A register write retires this cycle |
| ret_rd | output | 3 | Destination register of the retiring write |
| ret_data | output | 16 | Value written |
| st_valid | output | 1 | A data-memory write happens this cycle |
| st_addr | output | 16 | Computed store address |
| st_data | output | 16 | Stored value |

## Verification
The assertions take for granted that the program store is filled only while reset is held, and that the running program writes every data word before reading it. They rely on the load stream following reset, on flushed slots holding the word 0x0000, and on a stalled cycle leaving the PC unchanged. The stimulus stays within these limits in three ways. It loads all 64 program words during reset, including a no-op fill. It stores to a data address before the load that reads it. It ends the program in a jump to itself, so fetch never wanders into unwritten code. A load beat offered mid-run is the only deliberate step outside the accepted window, and its absence of effect is checked on the retire stream of a second run.

// File: rtl/pipe16_pkg.sv
package pipe16_pkg;
  localparam int XLEN = 16;
  localparam int RAW  = 3;
  localparam int OPW  = 4;
  localparam int IMMW = 6;
  localparam int JTW  = 12;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RAW-1:0]  ridx_t;

  localparam logic [OPW-1:0] OP_REG  = 4'd0;
  localparam logic [OPW-1:0] OP_SLTI = 4'd1;
  localparam logic [OPW-1:0] OP_LOAD = 4'd2;
  localparam logic [OPW-1:0] OP_STOR = 4'd3;
  localparam logic [OPW-1:0] OP_BEQ  = 4'd4;
  localparam logic [OPW-1:0] OP_JMP  = 4'd5;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_fn_e;

  typedef struct packed {
    logic    reg_wr;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
    logic    use_imm;
    alu_fn_e fn;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                                 branch: 1'b0, jump: 1'b0, use_imm: 1'b0,
                                 fn: ALU_ADD};

  typedef struct packed {
    word_t ins;
    word_t pc1;
  } ifid_t;

  typedef struct packed {
    ctrl_t          c;
    ridx_t          rs;
    ridx_t          rt;
    ridx_t          dst;
    word_t          a;
    word_t          b;
    word_t          imm;
    word_t          pc1;
    logic [JTW-1:0] jt;
  } idex_t;

  typedef struct packed {
    ctrl_t c;
    ridx_t dst;
    word_t y;
    word_t sd;
  } exmem_t;

  typedef struct packed {
    logic  wr;
    ridx_t dst;
    word_t wd;
  } memwb_t;

  function automatic ctrl_t decode_ctrl(input logic [OPW-1:0] op,
                                        input logic [2:0] fcode);
    ctrl_t c;
    c = CTRL_NOP;
    case (op)
      OP_REG: if (fcode <= 3'd4) begin
        c.reg_wr = 1'b1;
        c.fn     = alu_fn_e'(fcode);
      end
      OP_SLTI: begin
        c.reg_wr = 1'b1; c.use_imm = 1'b1; c.fn = ALU_SLT;
      end
      OP_LOAD: begin
        c.reg_wr = 1'b1; c.mem_rd = 1'b1; c.use_imm = 1'b1;
      end
      OP_STOR: begin
        c.mem_wr = 1'b1; c.use_imm = 1'b1;
      end
      OP_BEQ:  c.branch = 1'b1;
      OP_JMP:  c.jump   = 1'b1;
      default: c = CTRL_NOP;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe16_alu.sv
module pipe16_alu
  import pipe16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/pipe16_regfile.sv
module pipe16_regfile
  import pipe16_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = RAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        regs[g] <= '0;
        else if (we && wa == AW'(g))       regs[g] <= wd;
      end
    end
  end

  // same-cycle write is visible to the reader
  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] ra);
    if (ra == '0)               return '0;
    else if (we && wa == ra)    return wd;
    else                        return regs[ra];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
endmodule

// File: rtl/pipe16_hazard.sv
module pipe16_hazard
  import pipe16_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = RAW
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          mem_wr_reg,
  input  logic          mem_is_load,
  input  logic [AW-1:0] mem_dst,
  input  logic [W-1:0]  mem_val,
  input  logic          wb_wr_reg,
  input  logic [AW-1:0] wb_dst,
  input  logic [W-1:0]  wb_val,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [W-1:0]  ex_a,
  input  logic [W-1:0]  ex_b,
  output logic          stall,
  output logic [W-1:0]  fwd_a,
  output logic [W-1:0]  fwd_b
);
  assign stall = ex_is_load && (ex_dst != '0) &&
                 ((ex_dst == id_rs) || (ex_dst == id_rt));

  function automatic logic [W-1:0] pick(input logic [AW-1:0] r,
                                        input logic [W-1:0] held);
    if (r != '0 && mem_wr_reg && !mem_is_load && mem_dst == r) return mem_val;
    else if (r != '0 && wb_wr_reg && wb_dst == r)              return wb_val;
    else                                                       return held;
  endfunction

  assign fwd_a = pick(ex_rs, ex_a);
  assign fwd_b = pick(ex_rt, ex_b);
endmodule

// File: rtl/pipe16_core.sv
module pipe16_core
  import pipe16_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  output logic               ret_valid,
  output logic [RAW-1:0]     ret_rd,
  output logic [XLEN-1:0]    ret_data,
  output logic               st_valid,
  output logic [XLEN-1:0]    st_addr,
  output logic [XLEN-1:0]    st_data
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;
  localparam word_t ONE = XLEN'(1);

  word_t  imem [IDEPTH];
  word_t  dmem [DDEPTH];
  word_t  pc;
  ifid_t  ifid;
  idex_t  idex;
  exmem_t exmem;
  memwb_t memwb;

  // ---------------- program load stream
  assign ld_ready = !rst_n;
  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) imem[ld_addr] <= ld_data;
  end

  // ---------------- fetch
  word_t if_ins;
  assign if_ins = imem[pc[IMEM_AW-1:0]];

  // ---------------- decode
  ridx_t id_rs, id_rt, id_rd, id_dst;
  word_t id_a, id_b, id_imm;
  ctrl_t id_c;
  logic  [OPW-1:0] id_op;

  assign id_op  = ifid.ins[15:12];
  assign id_rs  = ifid.ins[11:9];
  assign id_rt  = ifid.ins[8:6];
  assign id_rd  = ifid.ins[5:3];
  assign id_c   = decode_ctrl(id_op, ifid.ins[2:0]);
  assign id_dst = (id_op == OP_REG) ? id_rd : id_rt;
  assign id_imm = {{(XLEN-IMMW){ifid.ins[IMMW-1]}}, ifid.ins[IMMW-1:0]};

  pipe16_regfile #(.W(XLEN), .AW(RAW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(memwb.wr), .wa(memwb.dst), .wd(memwb.wd),
    .ra1(id_rs), .ra2(id_rt), .rd1(id_a), .rd2(id_b)
  );

  // ---------------- execute
  logic  stall, ex_taken, ex_redirect;
  word_t ex_a, ex_b, ex_opb, ex_y, ex_target;

  pipe16_hazard #(.W(XLEN), .AW(RAW)) u_hz (
    .ex_is_load(idex.c.mem_rd), .ex_dst(idex.dst),
    .id_rs(id_rs), .id_rt(id_rt),
    .mem_wr_reg(exmem.c.reg_wr), .mem_is_load(exmem.c.mem_rd),
    .mem_dst(exmem.dst), .mem_val(exmem.y),
    .wb_wr_reg(memwb.wr), .wb_dst(memwb.dst), .wb_val(memwb.wd),
    .ex_rs(idex.rs), .ex_rt(idex.rt), .ex_a(idex.a), .ex_b(idex.b),
    .stall(stall), .fwd_a(ex_a), .fwd_b(ex_b)
  );

  assign ex_opb = idex.c.use_imm ? idex.imm : ex_b;

  pipe16_alu #(.W(XLEN)) u_alu (.a(ex_a), .b(ex_opb), .fn(idex.c.fn), .y(ex_y));

  assign ex_taken    = idex.c.branch && (ex_a == ex_b);
  assign ex_redirect = ex_taken || idex.c.jump;
  assign ex_target   = idex.c.jump ? XLEN'(idex.jt) : idex.pc1 + idex.imm;

  // ---------------- memory
  word_t mem_rdata;
  assign mem_rdata = dmem[exmem.y[DMEM_AW-1:0]];
  always_ff @(posedge clk) begin
    if (exmem.c.mem_wr) dmem[exmem.y[DMEM_AW-1:0]] <= exmem.sd;
  end

  // ---------------- pipeline registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      ifid  <= '0;
      idex  <= '{c: CTRL_NOP, default: '0};
      exmem <= '{c: CTRL_NOP, default: '0};
      memwb <= '0;
    end else begin
      if (ex_redirect) begin
        pc   <= ex_target;
        ifid <= '0;
      end else if (!stall) begin
        pc   <= pc + ONE;
        ifid <= '{ins: if_ins, pc1: pc + ONE};
      end

      if (ex_redirect || stall) begin
        idex <= '{c: CTRL_NOP, default: '0};
      end else begin
        idex <= '{c: id_c, rs: id_rs, rt: id_rt, dst: id_dst,
                  a: id_a, b: id_b, imm: id_imm, pc1: ifid.pc1,
                  jt: ifid.ins[JTW-1:0]};
      end

      exmem <= '{c: idex.c, dst: idex.dst, y: ex_y, sd: ex_b};
      memwb <= '{wr: exmem.c.reg_wr, dst: exmem.dst,
                 wd: exmem.c.mem_rd ? mem_rdata : exmem.y};
    end
  end

  // ---------------- outbound streams
  assign ret_valid = memwb.wr && (memwb.dst != '0);
  assign ret_rd    = memwb.dst;
  assign ret_data  = memwb.wd;
  assign st_valid  = exmem.c.mem_wr;
  assign st_addr   = exmem.y;
  assign st_data   = exmem.sd;
endmodule

// File: rtl/pipe16_chk.sv
module pipe16_chk
  import pipe16_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ld_ready,
  input logic       ret_valid,
  input logic [2:0] ret_rd,
  input logic       stall,
  input logic       redirect,
  input word_t      redirect_pc,
  input word_t      pc,
  input word_t      ifid_ins,
  input logic [2:0] id_rs,
  input word_t      id_a
);
  logic [2:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  // R1
  ld_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready);

  // R2
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (warm == 3'd4));

  // R12
  ret_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_rd != 3'd0));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> $stable(pc));

  // R10
  redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc == $past(redirect_pc)));

  // R10
  flush_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (ifid_ins == '0));

  // R7
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == 3'd0) |-> (id_a == '0));
endmodule

bind pipe16_core pipe16_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready),
  .ret_valid(ret_valid), .ret_rd(ret_rd),
  .stall(stall), .redirect(ex_redirect), .redirect_pc(ex_target),
  .pc(pc), .ifid_ins(ifid.ins), .id_rs(id_rs), .id_a(id_a)
);

// File: tb/test_pipe16_core.sv
module test_pipe16_core;
  localparam int PERIOD = 10;
  localparam int AW     = 6;
  localparam int NPROG  = 23;
  localparam int NEXP   = 12;
  localparam int RUNLEN = 40;

  localparam logic [15:0] PROG [NPROG] = '{
    16'h1041, 16'h0250, 16'h0458, 16'h02E1, 16'h08EA, 16'h0873,
    16'h087C, 16'h033C, 16'h19FF, 16'h3382, 16'h2143, 16'h0A78,
    16'h4285, 16'h46C2, 16'h0248, 16'h0490, 16'h5014, 16'h06D8,
    16'h06D8, 16'h0000, 16'h0240, 16'h0060, 16'h5016
  };

  // {rd, data, edge of retirement}
  localparam logic [26:0] EXPV [NEXP] = '{
    {3'd1, 16'h0001, 8'd4},  {3'd2, 16'h0002, 8'd5},
    {3'd3, 16'h0003, 8'd6},  {3'd4, 16'hFFFE, 8'd7},
    {3'd5, 16'h0002, 8'd8},  {3'd6, 16'hFFFF, 8'd9},
    {3'd7, 16'h0001, 8'd10}, {3'd7, 16'h0000, 8'd11},
    {3'd7, 16'h0001, 8'd12}, {3'd5, 16'hFFFF, 8'd14},
    {3'd7, 16'h0000, 8'd16}, {3'd4, 16'h0001, 8'd25}
  };
  localparam string TAGS [NEXP] = '{
    "R4", "R8", "R8", "R3", "R3", "R3", "R3", "R3", "R4", "R6", "R9", "R7"
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0]   ld_data = '0;
  logic          ret_valid;
  logic [2:0]    ret_rd;
  logic [15:0]   ret_data;
  logic          st_valid;
  logic [15:0]   st_addr;
  logic [15:0]   st_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nret = 0;
  int nst = 0;
  logic [26:0] got [32];
  logic [15:0] st_a_seen, st_d_seen;
  int          st_c_seen;

  pipe16_core #(.IMEM_AW(AW), .DMEM_AW(6)) i_pipe16_core (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_data(ret_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n && ret_valid) begin
      if (nret < 32) got[nret] = {ret_rd, ret_data, 8'(cyc)};
      nret++;
    end
    if (rst_n && st_valid) begin
      st_a_seen = st_addr; st_d_seen = st_data; st_c_seen = cyc;
      nst++;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_program(input bit poke_mid);
    nret = 0; nst = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < RUNLEN; k++) begin
      @(negedge clk);
      if (poke_mid && k == 3) begin
        // R1: load beat offered while running must be dropped
        check(ld_ready == 1'b0, "R1", "ld_ready while running", ld_ready, 0);
        ld_valid = 1'b1; ld_addr = AW'(21); ld_data = 16'h0028;
      end else begin
        ld_valid = 1'b0;
      end
    end
    ld_valid = 1'b0;
    // R12: retire stream walked against the expected table
    check(nret == NEXP, "R12", "retire count", nret, NEXP);
    for (int k = 0; k < NEXP; k++) begin
      check(got[k][26:24] == EXPV[k][26:24], TAGS[k], "retire rd",
            got[k][26:24], EXPV[k][26:24]);
      check(got[k][23:8] == EXPV[k][23:8], TAGS[k], "retire data",
            got[k][23:8], EXPV[k][23:8]);
      check(got[k][7:0] == EXPV[k][7:0], "R8", "retire edge",
            got[k][7:0], EXPV[k][7:0]);
    end
    // R5: one store, address r1+2 = 3, data 0xFFFF, on edge 12
    check(nst == 1, "R5", "store count", nst, 1);
    check(st_a_seen == 16'h0003, "R5", "store address", st_a_seen, 3);
    check(st_d_seen == 16'hFFFF, "R5", "store data", st_d_seen, 16'hFFFF);
    check(st_c_seen == 12, "R5", "store edge", st_c_seen, 12);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, RUNLEN);
    finish_run();
  end

  initial begin
    // R2: state during reset
    @(negedge clk);
    check(ld_ready == 1'b1, "R1", "ld_ready in reset", ld_ready, 1);
    check(ret_valid == 1'b0, "R2", "ret_valid in reset", ret_valid, 0);
    check(st_valid == 1'b0, "R2", "st_valid in reset", st_valid, 0);

    for (int a = 0; a < (1 << AW); a++) begin
      ld_valid = 1'b1;
      ld_addr  = AW'(a);
      ld_data  = (a < NPROG) ? PROG[a] : 16'h0000;
      @(negedge clk);
    end
    ld_valid = 1'b0;

    // first run: R3 R4 R6 R7 R8 R9 R10 R11 via table; load poke mid-run
    run_program(1'b1);

    // reset again: pipeline and registers clear, program unchanged (R1, R2)
    rst_n = 1'b0;
    @(negedge clk);
    check(ret_valid == 1'b0, "R2", "ret_valid after re-reset", ret_valid, 0);
    check(st_valid == 1'b0, "R2", "st_valid after re-reset", st_valid, 0);
    check(ld_ready == 1'b1, "R1", "ld_ready after re-reset", ld_ready, 1);
    // second run repeats the same retire trace: R10 and R11 flushes, R1 poke dropped
    run_program(1'b0);

    finish_run();
  end
endmodule